// File: doc/BRIEF.md
# Serial Front End for an Eight-Channel Sequenced Sampling Converter

This block is the digital serial slave of an eight-channel, 10-bit sampling converter. A host frames each transfer by pulling chip select low and clocking 16 serial-clock cycles. During each transfer a command word is shifted in on the data input, and a 16-bit result word is shifted out on the data output. A command with its write flag set loads a channel mask. The block then converts the selected channels one per frame, lowest channel number first. Each result leaves the block in the frame after the one that started its conversion.

The analog core is modelled by a parallel bus that carries one 10-bit sample per channel. A conversion captures the chosen channel's slice of that bus when the frame opens. The serial pins are sampled by the system clock through synchronizers, so the serial clock must run well below the system clock. When no result is pending, including after the selected channels have all been converted, the output word is all ones. A transfer that ends before its sixteenth rising serial-clock edge is discarded.

Top module: `adc_seq_spi_top`

## Requirements
- R1: After reset the serial output is high while chip select is high, and the first frame after reset returns 16'hFFFF.
- R2: A completed frame whose word has bit 15 set loads the channel mask from bits 13 down to 6, where bit 13 selects channel 0 and bit 6 selects channel 7. Bit 14 and bits 5:0 have no effect.
- R3: A conversion starts at the chip-select falling edge of the first frame after the mask is written, and its result is shifted out during the following frame.
- R4: When several channels are selected, each frame starts the conversion of the lowest selected channel not yet converted.
- R5: After the last selected channel has been returned, and whenever the mask is empty, every frame returns 16'hFFFF until a new write.
- R6: A completed frame whose bit 15 is clear changes neither the mask nor the progress of the sequence, and the sequence keeps advancing one channel per frame.
- R7: A result word has bit 15 = 0, the channel number in bits 14:12, the sample in bits 11:2, and bits 1:0 = 0. It is sent MSB first, with the output changing after falling serial-clock edges and the input sampled on rising edges.
- R8: If chip select rises before 16 rising serial-clock edges, the frame writes nothing and the sequence does not advance, so the next full frame returns the same word.
- R9: The value converted is the channel's sample-bus slice at the chip-select falling edge of the frame that starts the conversion. Later changes to the bus do not alter it.
- R10: A write during a sequence replaces the channels still pending with the new mask, and the conversion started in that same frame is still returned in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples all serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, idles low |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial command data in |
| spi_miso | output | 1 | Serial result data out |
| sample_bus | input | NUM_CH*RES_W | Per-channel samples; channel c at bits c*RES_W upward |

## Verification
A wrong pending mask appears within two frames: a skipped channel, a repeated channel or an out-of-order channel number shows up in bits 14:12 of the word after next. An early end of the sequence shows as a premature all-ones word. A broken abort path or bit counter shows on the next full frame as a repeated or missing result, or as a misaligned word. A capture made at the wrong time shows as a sample value taken from a different bus state than the one present when the converting frame opened.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int NUM_CH  = 8;
  localparam int RES_W   = 10;
  localparam int WORD_W  = 16;
  localparam int CH_AW   = $clog2(NUM_CH);
  localparam int CNT_W   = $clog2(WORD_W + 1);
  localparam int RX_W    = WORD_W - 1;
  localparam int PAD_W   = WORD_W - 1 - CH_AW - RES_W;

  typedef struct packed {
    logic             vld;
    logic [CH_AW-1:0] ch;
    logic [RES_W-1:0] data;
  } result_t;

  function automatic logic [WORD_W-1:0] pack_word(input result_t r);
    if (r.vld) pack_word = {1'b0, r.ch, r.data, {PAD_W{1'b0}}};
    else       pack_word = '1;
  endfunction
endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
  parameter int          N_BITS  = 3,
  parameter int          STAGES  = 2,
  parameter logic [2:0]  RST_VAL = 3'b010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_BITS-1:0] async_in,
  output logic [N_BITS-1:0] sync_out
);
  for (genvar b = 0; b < N_BITS; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;
    if (STAGES > 1) begin : g_deep
      assign chain_d = {chain_q[STAGES-2:0], async_in[b]};
    end else begin : g_flat
      assign chain_d = async_in[b];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL[b]}};
      else        chain_q <= chain_d;
    end
    assign sync_out[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/adc_seq_frame.sv
module adc_seq_frame
  import adc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              cs_n_s,
  input  logic              mosi_s,
  input  logic [WORD_W-1:0] load_word,
  output logic              frame_start,
  output logic              frame_done,
  output logic              frame_abort,
  output logic              cmd_write,
  output logic [NUM_CH-1:0] cmd_mask,
  output logic              miso
);
  logic              sclk_q, cs_q, in_frame_q, in_frame_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [RX_W-1:0]   rx_q, rx_d;
  logic [WORD_W-1:0] tx_q, tx_d;
  logic              sclk_rise, sclk_fall, cs_rise, full;

  assign frame_start = cs_q & ~cs_n_s;
  assign cs_rise     = ~cs_q & cs_n_s;
  assign sclk_rise   = in_frame_q & ~sclk_q & sclk_s;
  assign sclk_fall   = in_frame_q & sclk_q & ~sclk_s;
  assign full        = (cnt_q == CNT_W'(WORD_W));
  assign frame_done  = sclk_rise & (cnt_q == CNT_W'(WORD_W - 1));
  assign frame_abort = cs_rise & in_frame_q & ~full;

  // Decoded command fields valid during the frame_done pulse
  assign cmd_write = rx_q[RX_W-1];
  for (genvar i = 0; i < NUM_CH; i++) begin : g_mask
    assign cmd_mask[i] = rx_q[RX_W-3-i];
  end

  always_comb begin
    in_frame_d = in_frame_q;
    cnt_d      = cnt_q;
    rx_d       = rx_q;
    tx_d       = tx_q;
    if (frame_start) begin
      in_frame_d = 1'b1;
      cnt_d      = '0;
      tx_d       = load_word;
    end else if (cs_rise) begin
      in_frame_d = 1'b0;
      tx_d       = '1;
    end else begin
      if (sclk_rise && !full) begin
        cnt_d = cnt_q + 1'b1;
        rx_d  = {rx_q[RX_W-2:0], mosi_s};
      end
      if (sclk_fall) tx_d = {tx_q[WORD_W-2:0], 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q     <= 1'b0;
      cs_q       <= 1'b1;
      in_frame_q <= 1'b0;
      cnt_q      <= '0;
      rx_q       <= '0;
      tx_q       <= '1;
    end else begin
      sclk_q     <= sclk_s;
      cs_q       <= cs_n_s;
      in_frame_q <= in_frame_d;
      cnt_q      <= cnt_d;
      rx_q       <= rx_d;
      tx_q       <= tx_d;
    end
  end

  assign miso = tx_q[WORD_W-1];

  // R8: the edge counter never runs past one word
  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(WORD_W));
  // R1: outside a frame the output idles high
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !in_frame_q |-> miso);
  // R7: a new frame presents the loaded word's MSB on the next cycle
  a_r7_load_msb: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> miso == $past(load_word[WORD_W-1]));
endmodule

// File: rtl/adc_seq_core.sv
module adc_seq_core
  import adc_seq_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frame_start,
  input  logic                    frame_done,
  input  logic                    frame_abort,
  input  logic                    cmd_write,
  input  logic [NUM_CH-1:0]       cmd_mask,
  input  logic [NUM_CH*RES_W-1:0] sample_bus,
  output logic [WORD_W-1:0]       load_word
);
  logic [NUM_CH-1:0] pending_q, pending_d;
  result_t           cand_q, cand_d, res_q, res_d;
  logic [CH_AW-1:0]  sel_ch;
  logic              sel_vld;
  logic [NUM_CH-1:0] sel_onehot;

  // Lowest set bit of the pending mask wins
  always_comb begin
    sel_ch  = '0;
    sel_vld = 1'b0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (pending_q[i]) begin
        sel_ch  = CH_AW'(i);
        sel_vld = 1'b1;
      end
    end
  end

  always_comb begin
    sel_onehot = '0;
    if (cand_q.vld) sel_onehot[cand_q.ch] = 1'b1;
  end

  always_comb begin
    pending_d = pending_q;
    cand_d    = cand_q;
    res_d     = res_q;
    if (frame_start) begin
      cand_d.vld  = sel_vld;
      cand_d.ch   = sel_ch;
      cand_d.data = sample_bus[sel_ch*RES_W +: RES_W];
    end
    if (frame_done) begin
      res_d     = cand_q;
      pending_d = pending_q & ~sel_onehot;
      if (cmd_write) pending_d = cmd_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= '0;
      cand_q    <= '0;
      res_q     <= '0;
    end else begin
      pending_q <= pending_d;
      cand_q    <= cand_d;
      res_q     <= res_d;
    end
  end

  assign load_word = pack_word(res_q);

  // R4: without a write, completed frames only remove pending channels
  a_r4_no_new_chan: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && !cmd_write |=> (pending_q & ~$past(pending_q)) == '0);
  // R4: at most one channel retires per frame
  a_r4_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && !cmd_write |=>
      ($countones($past(pending_q)) - $countones(pending_q)) <= 1);
  // R8: an aborted frame leaves sequence and result untouched
  a_r8_abort_hold: assert property (@(posedge clk) disable iff (!rst_n)
    frame_abort |=> $stable(pending_q) && $stable(res_q));
  // R5: an empty mask starts no conversion
  a_r5_empty_idle: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && pending_q == '0 |=> !cand_q.vld);
  // R3: a completed frame publishes the conversion it started
  a_r3_publish: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> res_q == $past(cand_q));
endmodule

// File: rtl/adc_seq_spi_top.sv
module adc_seq_spi_top
  import adc_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    spi_sclk,
  input  logic                    spi_cs_n,
  input  logic                    spi_mosi,
  output logic                    spi_miso,
  input  logic [NUM_CH*RES_W-1:0] sample_bus
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [2:0]        pins_s;
  logic              frame_start, frame_done, frame_abort, cmd_write;
  logic [NUM_CH-1:0] cmd_mask;
  logic [WORD_W-1:0] load_word;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  adc_seq_sync #(.N_BITS(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .async_in ({spi_mosi, spi_cs_n, spi_sclk}),
    .sync_out (pins_s)
  );

  adc_seq_frame u_frame (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .sclk_s      (pins_s[0]),
    .cs_n_s      (pins_s[1]),
    .mosi_s      (pins_s[2]),
    .load_word   (load_word),
    .frame_start (frame_start),
    .frame_done  (frame_done),
    .frame_abort (frame_abort),
    .cmd_write   (cmd_write),
    .cmd_mask    (cmd_mask),
    .miso        (spi_miso)
  );

  adc_seq_core u_core (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .frame_start (frame_start),
    .frame_done  (frame_done),
    .frame_abort (frame_abort),
    .cmd_write   (cmd_write),
    .cmd_mask    (cmd_mask),
    .sample_bus  (sample_bus),
    .load_word   (load_word)
  );
endmodule

// File: tb/adc_seq_spi_top_tb_top.sv
module adc_seq_spi_top_tb_top;
  import adc_seq_pkg::*;

  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  logic [NUM_CH*RES_W-1:0] sample_bus = '0;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [7:0] m_pend = '0;
  logic       m_vld = 1'b0;
  logic [2:0] m_ch = '0;
  logic [9:0] m_data = '0;

  always #4 clk = ~clk;

  adc_seq_spi_top dut_i (
    .clk (clk), .rst_n (rst_n), .spi_sclk (sclk), .spi_cs_n (cs_n),
    .spi_mosi (mosi), .spi_miso (miso), .sample_bus (sample_bus)
  );

  function automatic logic [15:0] exp_word(logic v, logic [2:0] c, logic [9:0] d);
    return v ? {1'b0, c, d, 2'b00} : 16'hFFFF;
  endfunction

  function automatic logic [15:0] cmd(logic wr, logic [7:0] chans);
    logic [15:0] w;
    w = {wr, 1'b0, 14'h0};
    for (int i = 0; i < 8; i++) w[13-i] = chans[i];
    return w;
  endfunction

  task automatic wait_clks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string tag, logic [15:0] got, logic [15:0] exp, logic [15:0] msk);
    n_checks++;
    if ((got & msk) !== (exp & msk)) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h (mask %h)", tag, got, exp, msk);
    end
  endtask

  task automatic set_sample(int c, logic [9:0] v);
    sample_bus[c*RES_W +: RES_W] = v;
  endtask

  task automatic frame(logic [15:0] w, int nbits, string tag);
    logic [15:0] got, exp, msk;
    logic [7:0] snap_pend;
    logic [2:0] cc;
    logic cv;
    logic [9:0] cd;
    got = '1;
    snap_pend = m_pend;
    cv = 1'b0; cc = '0; cd = '0;
    for (int i = 7; i >= 0; i--) if (snap_pend[i]) begin cv = 1'b1; cc = 3'(i); end
    cd = sample_bus[int'(cc)*RES_W +: RES_W];
    cs_n = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      mosi = w[15-i];
      wait_clks(HALF);
      got[15-i] = miso;
      sclk = 1'b1;
      wait_clks(HALF);
      sclk = 1'b0;
    end
    wait_clks(HALF);
    cs_n = 1'b1;
    wait_clks(10);
    exp = exp_word(m_vld, m_ch, m_data);
    msk = ~(16'hFFFF >> nbits);
    if (tag == "") tag = m_vld ? "R7 R3 R4" : "R5";
    if (nbits > 0) check(tag, got, exp, msk);
    if (nbits == 16) begin
      m_vld = cv; m_ch = cc; m_data = cd;
      if (cv) m_pend[cc] = 1'b0;
      if (w[15]) for (int i = 0; i < 8; i++) m_pend[i] = w[13-i];
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd20240611));
    for (int c = 0; c < 8; c++) set_sample(c, 10'(c * 37 + 5));
    wait_clks(5);
    rst_n = 1'b1;
    wait_clks(6);
    check("R1 idle", {15'h0, miso}, 16'h1, 16'h1);
    // R1 first frame all ones, writes channel 1
    frame(cmd(1'b1, 8'b0000_0010), 16, "R1");
    frame(16'h0000, 16, "R3");
    frame(16'h0000, 16, "R3 R7");
    frame(16'h0000, 16, "R5");
    // R2 mapping: bit 6 selects channel 7
    frame(16'h8040 | 16'h403F, 16, "R5");
    frame(16'h0000, 16, "R2");
    frame(16'h0000, 16, "R2 R7");
    // R4 ascending order for channels 0, 3, 7
    frame(cmd(1'b1, 8'b1000_1001), 16, "R5");
    frame(16'h0000, 16, "R4");
    // R6 write flag clear with all mask bits set
    frame(16'h7FFF, 16, "R4 R6");
    frame(16'h0000, 16, "R4 R6");
    frame(16'h0000, 16, "R4");
    frame(16'h0000, 16, "R5");
    // R9: capture at the converting frame's start
    frame(cmd(1'b1, 8'b0000_0100), 16, "R5");
    set_sample(2, 10'h2AA);
    frame(16'h0000, 16, "R9");
    set_sample(2, 10'h155);
    frame(16'h0000, 16, "R9");
    // R8 aborted frames then full frames
    frame(cmd(1'b1, 8'b0011_0000), 16, "R5");
    frame(16'h0000, 16, "R8");
    frame(cmd(1'b1, 8'hFF), 7, "R8");
    frame(16'h0000, 0, "R8");
    frame(16'h0000, 16, "R8");
    frame(16'h0000, 15, "R8");
    frame(16'h0000, 16, "R8");
    // R10 rewrite mid-sequence
    frame(cmd(1'b1, 8'b0000_1110), 16, "R10");
    frame(16'h0000, 16, "R10");
    frame(cmd(1'b1, 8'b0100_0000), 16, "R10");
    frame(16'h0000, 16, "R10");
    frame(16'h0000, 16, "R10");
    // R5 empty mask
    frame(cmd(1'b1, 8'h00), 16, "R5");
    frame(16'h0000, 16, "R5");
    // Constrained random traffic
    for (int k = 0; k < 250; k++) begin
      int nb;
      logic [15:0] w;
      for (int c = 0; c < 8; c++) set_sample(c, 10'($urandom_range(0, 1023)));
      w = 16'($urandom);
      w[15] = ($urandom_range(0, 9) < 3);
      nb = ($urandom_range(0, 9) == 0) ? $urandom_range(0, 15) : 16;
      frame(w, nb, "");
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule